// File: doc/BRIEF.md
# Paged Address Translation Unit

This block sits between a CPU with a 16-bit address bus and a wider physical memory. The CPU space is cut into sixteen 4 KB pages. Each page is looked up in a table of page entries and replaced by a physical frame number. The low twelve address bits pass through unchanged. The table holds one complete set of sixteen entries per task, and a task register picks which set is in force. Software can switch a whole memory map with a single register write.

Each page entry also carries attribute bits. The read-only bit stops a CPU write from reaching memory. The write-interrupt bit raises a sticky interrupt when the page is written, and the status records which page did it. A third bit is spare storage with no effect. The CPU reads and writes the entries of the current task, the task register and the status through a 32-location register window. After reset, task 0 maps every page onto the frame of the same number, so the CPU can boot before any entry has been written.

Top module: `paged_xlat`

## Requirements
- R1: While rst_n is low and after it rises, the task register is 0, irq is 0 and the status reads 0x0000. Page n of task 0 holds frame n with all attributes clear. Every entry of every other task holds frame 0 with all attributes clear.
- R2: phys_addr is the frame field of the current task's entry for page cpu_addr[15:12], placed above cpu_addr[11:0]. The path is combinational, so the result is valid in the same cycle as cpu_addr.
- R3: Window map, reached when reg_sel is 1: locations 0x00–0x0F are the current task's entries for pages 0–15, 0x10 is the task register and 0x11 is the status. An entry is laid out with frame in bits [FRAME_W-1:0], read-only in bit 13, write-interrupt in bit 14 and the spare bit in bit 15. Frame bits from FRAME_W up to bit 12 read as 0. Locations 0x12–0x1F read 0 and ignore writes, and reg_rdata is 0 when reg_sel is 0.
- R4: A register write (reg_sel=1, reg_we=1) is taken at a clock edge and governs translation and read-back from the next cycle on.
- R5: The task register (TASK_W bits, zero-extended on read) selects the set of 16 entries used for translation and for window access. Entries of the other tasks keep their contents.
- R6: mem_wr_inhibit is 1 exactly when cpu_wr is 1 and the addressed page has the read-only bit set. A read of such a page gives 0.
- R7: A CPU write (cpu_wr=1) to a page whose write-interrupt bit is set makes irq 1 from the next cycle on. The status then reads bit 15 = 1 and bits [3:0] = that page number. A CPU read of the page never raises irq.
- R8: irq stays 1 until a window write to the status with bit 15 = 1, which clears irq and the status to 0x0000 in the next cycle. A status write with bit 15 = 0 clears nothing. Later interrupting writes keep the first latched page, and a hit in the same cycle as a clear wins.
- R9: The spare bit 15 of an entry reads back as written and has no effect on phys_addr, mem_wr_inhibit or irq.
- R10: phys_addr is FRAME_W+12 bits wide: FRAME_W=8 (the default) covers 1 MB, and 13 covers 32 MB. Every frame value from 0 up to 2^FRAME_W-1 translates, the top page included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU logical address |
| cpu_wr | input | 1 | CPU memory access is a write |
| reg_sel | input | 1 | Register window selected |
| reg_we | input | 1 | Register window write strobe |
| reg_addr | input | 5 | Register window location |
| reg_wdata | input | 16 | Register window write data |
| reg_rdata | output | 16 | Register window read data |
| phys_addr | output | FRAME_W+12 | Translated physical address |
| mem_wr_inhibit | output | 1 | Blocks the current write to memory |
| irq | output | 1 | Sticky write-interrupt request |

## Verification
phys_addr, mem_wr_inhibit and reg_rdata are combinational, so the bench expects them in the cycle it drives the inputs and compares them 2 ns after that falling edge. Window writes and the interrupt status are registered once. A check that depends on them is queued at the next falling edge, which is the first cycle after the capturing rising edge. This timing also proves that a register write acts on the very next CPU cycle. The driver pushes each expectation into a queue as it drives, and a monitor drains the queue at a fixed offset after every falling edge, so no comparison lands on a clock edge.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  localparam int VA_W      = 16;
  localparam int OFF_W     = 12;
  localparam int PG_W      = VA_W - OFF_W;
  localparam int NPAGES    = 1 << PG_W;
  localparam int REG_W     = 16;
  localparam int RADDR_W   = 5;
  localparam int FRAME_MAX = 13;

  localparam logic [RADDR_W-1:0] WIN_TASK = 5'h10;
  localparam logic [RADDR_W-1:0] WIN_STAT = 5'h11;

  // entry layout as seen on the register window
  typedef struct packed {
    logic                 spare;
    logic                 wirq;
    logic                 ronly;
    logic [FRAME_MAX-1:0] frame;
  } pte_t;

  function automatic logic [PG_W-1:0] page_of(input logic [VA_W-1:0] a);
    return a[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] offset_of(input logic [VA_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  // bus word to stored entry, frame bits beyond the configured width forced low
  function automatic pte_t pte_from_bus(input logic [REG_W-1:0] d, input int unsigned fw);
    pte_t e;
    e = pte_t'(d);
    for (int i = 0; i < FRAME_MAX; i++) begin
      if (i >= int'(fw)) e.frame[i] = 1'b0;
    end
    return e;
  endfunction

  function automatic pte_t pte_identity(input int unsigned pg);
    pte_t e;
    e = '0;
    e.frame = FRAME_MAX'(pg);
    return e;
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic pend,
                                                   input logic [PG_W-1:0] pg);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1] = pend;
    w[PG_W-1:0] = pg;
    return w;
  endfunction
endpackage

// File: rtl/pxu_page_store.sv
module pxu_page_store
  import pxu_pkg::*;
#(
  parameter int TASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TASK_W-1:0] cur_task,
  input  logic [PG_W-1:0]   wr_page,
  input  pte_t              wr_pte,
  input  logic [PG_W-1:0]   xl_page,
  input  logic [PG_W-1:0]   rd_page,
  output pte_t              xl_pte,
  output pte_t              rd_pte
);
  localparam int NSETS = 1 << TASK_W;

  pte_t tbl [NSETS][NPAGES];

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    for (genvar p = 0; p < NPAGES; p++) begin : g_page
      pte_t cell_q;
      logic hit;
      assign hit = wr_en && (cur_task == TASK_W'(s)) && (wr_page == PG_W'(p));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cell_q <= (s == 0) ? pte_identity(p) : '0;
        end else if (hit) begin
          cell_q <= wr_pte;
        end
      end
      assign tbl[s][p] = cell_q;
    end
  end

  assign xl_pte = tbl[cur_task][xl_page];
  assign rd_pte = tbl[cur_task][rd_page];
endmodule

// File: rtl/pxu_regwin.sv
module pxu_regwin
  import pxu_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int TASK_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  pte_t               rd_pte,
  input  logic               pend,
  input  logic [PG_W-1:0]    pend_page,
  output logic [TASK_W-1:0]  task_q,
  output logic               task_we,
  output logic               pte_we,
  output logic [PG_W-1:0]    pte_page,
  output pte_t               pte_wdata,
  output logic               status_clr,
  output logic [REG_W-1:0]   reg_rdata
);
  logic wr_cyc;
  logic in_tbl;

  assign wr_cyc   = reg_sel && reg_we;
  assign in_tbl   = (reg_addr[RADDR_W-1] == 1'b0);
  assign pte_we   = wr_cyc && in_tbl;
  assign pte_page = reg_addr[PG_W-1:0];
  assign pte_wdata = pte_from_bus(reg_wdata, FRAME_W);
  assign task_we  = wr_cyc && (reg_addr == WIN_TASK);
  assign status_clr = wr_cyc && (reg_addr == WIN_STAT) && reg_wdata[REG_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      task_q <= '0;
    end else if (task_we) begin
      task_q <= reg_wdata[TASK_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      if (in_tbl) begin
        reg_rdata = REG_W'(rd_pte);
      end else if (reg_addr == WIN_TASK) begin
        reg_rdata = REG_W'(task_q);
      end else if (reg_addr == WIN_STAT) begin
        reg_rdata = status_word(pend, pend_page);
      end
    end
  end
endmodule

// File: rtl/pxu_wevent.sv
module pxu_wevent
  import pxu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_wr,
  input  logic [PG_W-1:0] cpu_page,
  input  logic            page_wirq,
  input  logic            status_clr,
  output logic            irq_hit,
  output logic            pend_q,
  output logic [PG_W-1:0] pend_page
);
  assign irq_hit = cpu_wr && page_wirq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      pend_page <= '0;
    end else if (irq_hit) begin
      pend_q <= 1'b1;
      if (!pend_q || status_clr) pend_page <= cpu_page;
    end else if (status_clr) begin
      pend_q    <= 1'b0;
      pend_page <= '0;
    end
  end
endmodule

// File: rtl/paged_xlat.sv
module paged_xlat
  import pxu_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int TASK_W  = 4,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [VA_W-1:0]    cpu_addr,
  input  logic               cpu_wr,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [RADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [PA_W-1:0]    phys_addr,
  output logic               mem_wr_inhibit,
  output logic               irq
);
  logic [TASK_W-1:0] task_q;
  logic              task_we;
  logic              pte_we;
  logic [PG_W-1:0]   pte_page;
  pte_t              pte_wdata;
  pte_t              xl_pte;
  pte_t              rd_pte;
  logic              status_clr;
  logic              irq_hit;
  logic              pend_q;
  logic [PG_W-1:0]   pend_page;
  logic [PG_W-1:0]   cpu_page;
  logic              unused_xl_bits;

  assign cpu_page = page_of(cpu_addr);

  pxu_regwin #(.FRAME_W(FRAME_W), .TASK_W(TASK_W)) u_win (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_pte(rd_pte), .pend(pend_q), .pend_page(pend_page),
    .task_q(task_q), .task_we(task_we),
    .pte_we(pte_we), .pte_page(pte_page), .pte_wdata(pte_wdata),
    .status_clr(status_clr), .reg_rdata(reg_rdata)
  );

  pxu_page_store #(.TASK_W(TASK_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(pte_we), .cur_task(task_q), .wr_page(pte_page), .wr_pte(pte_wdata),
    .xl_page(cpu_page), .rd_page(reg_addr[PG_W-1:0]),
    .xl_pte(xl_pte), .rd_pte(rd_pte)
  );

  pxu_wevent u_evt (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr(cpu_wr), .cpu_page(cpu_page), .page_wirq(xl_pte.wirq),
    .status_clr(status_clr),
    .irq_hit(irq_hit), .pend_q(pend_q), .pend_page(pend_page)
  );

  assign phys_addr      = {xl_pte.frame[FRAME_W-1:0], offset_of(cpu_addr)};
  assign mem_wr_inhibit = cpu_wr && xl_pte.ronly;
  assign irq            = pend_q;
  assign unused_xl_bits = ^{xl_pte.spare, xl_pte.frame};
endmodule

// File: rtl/paged_xlat_chk.sv
module paged_xlat_chk
  import pxu_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int TASK_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [VA_W-1:0]         cpu_addr,
  input logic                    cpu_wr,
  input logic [FRAME_W+OFF_W-1:0] phys_addr,
  input logic                    mem_wr_inhibit,
  input logic                    irq,
  input logic                    irq_hit,
  input logic                    status_clr,
  input logic                    task_we,
  input logic [TASK_W-1:0]       task_q,
  input logic [PG_W-1:0]         pend_page
);
  a_r2_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFF_W-1:0] == cpu_addr[OFF_W-1:0]);

  a_r6_inhibit_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_inhibit |-> cpu_wr);

  a_r7_hit_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hit |=> irq);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !status_clr) |=> irq);

  a_r8_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !irq_hit) |=> !irq);

  a_r8_page_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !status_clr) |=> $stable(pend_page));

  a_r5_task_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !task_we |=> $stable(task_q));
endmodule

bind paged_xlat paged_xlat_chk #(.FRAME_W(FRAME_W), .TASK_W(TASK_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .phys_addr(phys_addr), .mem_wr_inhibit(mem_wr_inhibit), .irq(irq),
  .irq_hit(irq_hit), .status_clr(status_clr), .task_we(task_we),
  .task_q(task_q), .pend_page(pend_page)
);

// File: tb/paged_xlat_tb_top.sv
module paged_xlat_tb_top;
  localparam int FW = 8;
  localparam int PA = FW + 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cpu_addr = '0;
  logic          cpu_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic          reg_we = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [PA-1:0] phys_addr;
  logic          mem_wr_inhibit;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  paged_xlat #(.FRAME_W(FW), .TASK_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .phys_addr(phys_addr),
    .mem_wr_inhibit(mem_wr_inhibit), .irq(irq)
  );

  // kinds: 0 phys_addr, 1 mem_wr_inhibit, 2 irq, 3 reg_rdata
  typedef struct {
    int          kind;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t sb[$];

  function automatic logic [15:0] ent(input bit sp, input bit wi, input bit ro,
                                      input logic [12:0] fr);
    return {sp, wi, ro, fr};
  endfunction

  function automatic logic [31:0] xl(input logic [FW-1:0] fr, input logic [15:0] a);
    return (32'(fr) << 12) | 32'(a & 16'h0FFF);
  endfunction

  task automatic push(input int k, input logic [31:0] v, input string t);
    item_t it;
    it.kind = k; it.val = v; it.tag = t;
    sb.push_back(it);
  endtask

  // monitor: drains the expectations queued for this cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        case (it.kind)
          0: act = 32'(phys_addr);
          1: act = 32'(mem_wr_inhibit);
          2: act = 32'(irq);
          default: act = 32'(reg_rdata);
        endcase
        checks++;
        if (act !== it.val) begin
          errors++;
          $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h", it.tag, it.kind, act, it.val);
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    cpu_wr = 1'b0; reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    cpu_wr = 1'b0; reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic reg_read(input logic [4:0] a, input logic [15:0] exp, input string t);
    @(negedge clk);
    cpu_wr = 1'b0; reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    push(3, 32'(exp), t);
  endtask

  task automatic cpu(input logic [15:0] a, input bit wr, input logic [FW-1:0] fr,
                     input bit inh, input string t);
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0; cpu_addr = a; cpu_wr = wr;
    push(0, xl(fr, a), t);
    push(1, 32'(inh), t);
  endtask

  task automatic chk_irq(input bit v, input string t);
    idle();
    push(2, 32'(v), t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    push(2, 32'd0, "R1 irq in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R1 state after reset
    reg_read(5'h10, 16'h0000, "R1 task reg");
    reg_read(5'h05, 16'h0005, "R1 identity entry");
    reg_read(5'h11, 16'h0000, "R1 status");
    cpu(16'h5ABC, 1'b0, 8'h05, 1'b0, "R1 identity translation");
    chk_irq(1'b0, "R1 irq after reset");

    // R2/R4 new frame used in the very next cycle
    reg_write(5'h03, ent(0, 0, 0, 13'h0A7));
    cpu(16'h3123, 1'b0, 8'hA7, 1'b0, "R4 next-cycle effect");
    cpu(16'h2FFF, 1'b0, 8'h02, 1'b0, "R2 neighbour page");

    // R10 top page and top frame; R3 high frame bits dropped
    reg_write(5'h0F, ent(0, 0, 0, 13'h0FF));
    cpu(16'hFFFF, 1'b0, 8'hFF, 1'b0, "R10 top frame top page");
    reg_write(5'h01, ent(0, 0, 0, 13'h1ABC));
    reg_read(5'h01, 16'h00BC, "R3 frame bits above FRAME_W");
    cpu(16'h1000, 1'b0, 8'hBC, 1'b0, "R10 truncated frame");
    reg_read(5'h15, 16'h0000, "R3 unused location");
    idle();
    push(3, 32'h0, "R3 rdata without select");

    // R5 per-task sets
    reg_write(5'h10, 16'h0002);
    reg_read(5'h10, 16'h0002, "R5 task readback");
    reg_read(5'h03, 16'h0000, "R1 other task reset entry");
    cpu(16'h3123, 1'b0, 8'h00, 1'b0, "R5 task 2 translation");
    reg_write(5'h03, ent(0, 0, 0, 13'h044));
    cpu(16'h3456, 1'b0, 8'h44, 1'b0, "R5 task 2 new frame");
    reg_write(5'h10, 16'h0000);
    cpu(16'h3123, 1'b0, 8'hA7, 1'b0, "R5 task 0 kept");
    reg_read(5'h03, 16'h00A7, "R5 task 0 entry kept");

    // R6 read-only
    reg_write(5'h07, ent(0, 0, 1, 13'h070));
    reg_read(5'h07, 16'h2070, "R3 ro bit position");
    cpu(16'h7010, 1'b1, 8'h70, 1'b1, "R6 write blocked");
    cpu(16'h7010, 1'b0, 8'h70, 1'b0, "R6 read allowed");
    cpu(16'h6010, 1'b1, 8'h06, 1'b0, "R6 other page write");

    // R7 write interrupt
    reg_write(5'h09, ent(0, 1, 0, 13'h009));
    cpu(16'h9000, 1'b0, 8'h09, 1'b0, "R7 read of irq page");
    chk_irq(1'b0, "R7 read raises nothing");
    cpu(16'h9004, 1'b1, 8'h09, 1'b0, "R7 write of irq page");
    chk_irq(1'b1, "R7 irq next cycle");
    reg_read(5'h11, 16'h8009, "R7 status page");

    // R8 sticky, first page kept, clear rules
    reg_write(5'h0A, ent(0, 1, 0, 13'h00A));
    cpu(16'hA000, 1'b1, 8'h0A, 1'b0, "R8 second hit");
    chk_irq(1'b1, "R8 still set");
    reg_read(5'h11, 16'h8009, "R8 first page kept");
    reg_write(5'h11, 16'h0000);
    chk_irq(1'b1, "R8 bit15=0 does not clear");
    reg_write(5'h11, 16'h8000);
    chk_irq(1'b0, "R8 cleared");
    reg_read(5'h11, 16'h0000, "R8 status after clear");
    cpu(16'hA010, 1'b1, 8'h0A, 1'b0, "R8 new hit");
    chk_irq(1'b1, "R8 rearmed");
    reg_read(5'h11, 16'h800A, "R8 new page latched");
    reg_write(5'h11, 16'h8000);
    chk_irq(1'b0, "R8 cleared again");

    // R9 spare bit
    reg_write(5'h0B, ent(1, 0, 0, 13'h00B));
    reg_read(5'h0B, 16'h800B, "R9 spare readback");
    cpu(16'hB000, 1'b1, 8'h0B, 1'b0, "R9 spare no inhibit");
    chk_irq(1'b0, "R9 spare no irq");

    idle();
    idle();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule